// File: doc/BRIEF.md
# Multi-format audio serial transmitter

This block turns stereo PCM sample pairs into a serial bit stream on a three-wire audio link, acting as clock master. It divides the system clock to make a bit clock with 64 bit slots per stereo frame, drives a word clock that marks the channels, and shifts sample bits out MSB first on a serial data line. Four framings are available: I2S, left-justified, right-justified and a DSP-style framing with a one-slot sync pulse. A single alternate-select bit inverts the word clock in the first three framings and picks the earlier of the two DSP data positions in the fourth.

Samples arrive as 24-bit left/right pairs through a valid/ready handshake into a one-entry holding register. Each frame consumes the held pair at its first slot. If no pair is waiting, the frame carries silence. The word length (16, 20 or 24 bits) and the framing are captured at the start of each frame. Samples are shortened to the word length by dropping their low bits. Every slot that carries no sample bit is driven low.

Top module: `aud_serial_tx`

## Requirements
- R1: While `rst` is high and in the cycle after it, `bclk`, `lrclk` and `sdo` are 0 and `in_ready` is 1.
- R2: `bclk` has a period of 2*DIV system clocks, low for the first DIV and high for the second, giving 64 periods (slots 0 to 63) per frame; `sdo` and `lrclk` change only in the cycle where `bclk` falls. The first fall after reset starts slot 0, and it comes DIV+1 cycles after reset is released.
- R3: Framing code 0 (I2S): `lrclk` is 0 in slots 0..31 (left) and 1 in slots 32..63 (right); each channel's MSB is in the slot after the word-clock edge (slots 1 and 33).
- R4: Framing code 1 (left-justified): `lrclk` is 1 in slots 0..31 (left) and 0 in 32..63; each MSB is in slot 0 or 32, so it changes on the same falling edge as the word clock.
- R5: Framing code 2 (right-justified): word clock as in R4; each LSB sits in slot 31 or 63, the slot just before the word-clock transition.
- R6: Framing code 3 (DSP): `lrclk` is 1 only in slot 0; the left MSB is in slot 1 when `cfg_alt`=0 and in slot 0 when `cfg_alt`=1, and the right sample follows the left LSB with no gap.
- R7: With `cfg_alt`=1 in framing codes 0..2, `lrclk` is the inverse of its R3/R4/R5 value, while data slots are unchanged.
- R8: `cfg_wl` code 0 gives 16 bits, 1 gives 20, 2 and 3 give 24. A sample is shortened by keeping its top bits `in_left[23 -: W]`, sent MSB first.
- R9: Every slot outside a channel's data bits carries `sdo`=0.
- R10: `in_ready` is 1 exactly when the holding register is empty. A pair is taken when `in_valid` and `in_ready` are both 1. The frame that starts in slot 0 takes the held pair and empties the register. If the register is empty at that point, the frame sends zeros.
- R11: `cfg_fmt`, `cfg_alt` and `cfg_wl` are sampled only in the cycle that starts slot 0; a change during a frame affects only the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fmt | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 DSP |
| cfg_alt | input | 1 | Word-clock invert (codes 0..2) / early DSP data position (code 3) |
| cfg_wl | input | 2 | Word length: 0=16, 1=20, 2/3=24 bits |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Holding register empty |
| in_left | input | 24 | Left sample, MSB aligned |
| in_right | input | 24 | Right sample, MSB aligned |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Word clock |
| sdo | output | 1 | Serial data |

## Verification
The hardest cases to reach are a configuration change in the middle of a frame and a frame that starts with an empty holding register. To reach both, the stimulus steps through all 32 settings of framing, alternate bit and word length at a spacing that does not divide the frame length. It also withholds `in_valid` for long stretches so that silent frames appear. A behavioural model in the bench builds each frame's 64-slot bit and word-clock patterns from the latched settings and compares all outputs on every clock.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

    localparam int SAMPLE_W    = 24;
    localparam int FRAME_SLOTS = 64;
    localparam int SLOT_W      = $clog2(FRAME_SLOTS);
    localparam int HALF_SLOTS  = FRAME_SLOTS / 2;
    localparam int IDX_W       = $clog2(SAMPLE_W);

    typedef enum logic [1:0] {
        FMT_I2S = 2'd0,
        FMT_LJ  = 2'd1,
        FMT_RJ  = 2'd2,
        FMT_DSP = 2'd3
    } fmt_e;

    typedef struct packed {
        fmt_e       fmt;
        logic       alt;
        logic [1:0] wl;
    } cfg_t;

    typedef struct packed {
        logic [SAMPLE_W-1:0] l;
        logic [SAMPLE_W-1:0] r;
    } pair_t;

    typedef struct packed {
        logic             lr;
        logic             act;
        logic             right;
        logic [IDX_W-1:0] idx;
    } slot_t;

    function automatic int wl_bits(logic [1:0] wl);
        case (wl)
            2'd0:    return 16;
            2'd1:    return 20;
            default: return 24;
        endcase
    endfunction

    // Decide word-clock level and which sample bit (if any) a slot carries.
    function automatic slot_t map_slot(cfg_t c, logic [SLOT_W-1:0] slot);
        slot_t m;
        int    w, pos, s0, off;
        logic  half;
        w    = wl_bits(c.wl);
        pos  = int'(slot[SLOT_W-2:0]);
        half = slot[SLOT_W-1];
        m    = '0;
        case (c.fmt)
            FMT_I2S: begin
                m.lr    = half ^ c.alt;
                m.right = half;
                m.act   = (pos >= 1) && (pos <= w);
                m.idx   = IDX_W'(pos - 1);
            end
            FMT_LJ: begin
                m.lr    = ~half ^ c.alt;
                m.right = half;
                m.act   = pos < w;
                m.idx   = IDX_W'(pos);
            end
            FMT_RJ: begin
                m.lr    = ~half ^ c.alt;
                m.right = half;
                m.act   = pos >= HALF_SLOTS - w;
                m.idx   = IDX_W'(pos - (HALF_SLOTS - w));
            end
            default: begin
                s0      = c.alt ? 0 : 1;
                off     = int'(slot) - s0;
                m.lr    = (slot == '0);
                m.act   = (off >= 0) && (off < 2 * w);
                m.right = off >= w;
                m.idx   = IDX_W'(m.right ? off - w : off);
            end
        endcase
        return m;
    endfunction

endpackage

// File: rtl/aud_tx_clkgen.sv
module aud_tx_clkgen
    import aud_tx_pkg::*;
#(
    parameter int DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    output logic              fall_tick,
    output logic              rise_tick,
    output logic [SLOT_W-1:0] slot,
    output logic [SLOT_W-1:0] next_slot
);
    localparam int PERIOD = 2 * DIV;
    localparam int CNT_W  = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [CNT_W-1:0] div_cnt;

    assign fall_tick = (div_cnt == CNT_W'(PERIOD - 1));
    assign rise_tick = (div_cnt == CNT_W'(DIV - 1));
    assign next_slot = slot + 1'b1;

    // Reset lands just before the first rising half so slot 0 opens on a fall.
    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= CNT_W'(DIV - 1);
            slot    <= SLOT_W'(FRAME_SLOTS - 1);
        end else if (fall_tick) begin
            div_cnt <= '0;
            slot    <= next_slot;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/aud_tx_frame.sv
module aud_tx_frame
    import aud_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  cfg_t                cfg_in,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    output logic                in_ready,
    output pair_t               next_pair,
    output cfg_t                next_cfg,
    output cfg_t                cur_cfg
);
    logic  pend_v;
    pair_t pend;
    pair_t cur_pair;
    logic  take;

    assign in_ready  = ~pend_v;
    assign take      = in_valid & in_ready;
    assign next_pair = load ? (pend_v ? pend : '0) : cur_pair;
    assign next_cfg  = load ? cfg_in : cur_cfg;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v   <= 1'b0;
            pend     <= '0;
            cur_pair <= '0;
            cur_cfg  <= '0;
        end else begin
            if (load) begin
                cur_pair <= next_pair;
                cur_cfg  <= cfg_in;
            end
            if (take) begin
                pend_v <= 1'b1;
                pend   <= '{l: in_left, r: in_right};
            end else if (load) begin
                pend_v <= 1'b0;
            end
        end
    end

    AST_TAKE_FILLS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready); // R10
    AST_LOAD_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (load && !(in_valid && in_ready)) |=> in_ready); // R10

endmodule

// File: rtl/aud_serial_tx.sv
module aud_serial_tx
    import aud_tx_pkg::*;
#(
    parameter int DIV = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  cfg_fmt,
    input  logic        cfg_alt,
    input  logic [1:0]  cfg_wl,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [23:0] in_left,
    input  logic [23:0] in_right,
    output logic        bclk,
    output logic        lrclk,
    output logic        sdo
);
    logic              fall_tick, rise_tick, load;
    logic [SLOT_W-1:0] slot, next_slot;
    cfg_t              cfg_in, next_cfg, cur_cfg;
    pair_t             next_pair;
    slot_t             sm;
    logic [SAMPLE_W-1:0] word;
    logic [IDX_W-1:0]  bit_pos;

    assign cfg_in = '{fmt: fmt_e'(cfg_fmt), alt: cfg_alt, wl: cfg_wl};
    assign load   = fall_tick && (next_slot == '0);

    aud_tx_clkgen #(.DIV(DIV)) i_clkgen (
        .clk       (clk),
        .rst       (rst),
        .fall_tick (fall_tick),
        .rise_tick (rise_tick),
        .slot      (slot),
        .next_slot (next_slot)
    );

    aud_tx_frame i_frame (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .cfg_in    (cfg_in),
        .in_valid  (in_valid),
        .in_left   (in_left),
        .in_right  (in_right),
        .in_ready  (in_ready),
        .next_pair (next_pair),
        .next_cfg  (next_cfg),
        .cur_cfg   (cur_cfg)
    );

    always_comb begin
        sm      = map_slot(next_cfg, next_slot);
        word    = sm.right ? next_pair.r : next_pair.l;
        bit_pos = IDX_W'(SAMPLE_W - 1) - sm.idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk  <= 1'b0;
            lrclk <= 1'b0;
            sdo   <= 1'b0;
        end else if (fall_tick) begin
            bclk  <= 1'b0;
            lrclk <= sm.lr;
            sdo   <= sm.act ? word[bit_pos] : 1'b0;
        end else if (rise_tick) begin
            bclk  <= 1'b1;
        end
    end

    AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sdo) && !$past(rst)) |-> $fell(bclk)); // R2
    AST_LR_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (!$stable(lrclk) && !$past(rst)) |-> $fell(bclk)); // R2
    AST_DSP_ONE_SLOT: assert property (@(posedge clk) disable iff (rst)
        ((cur_cfg.fmt == FMT_DSP) && $fell(lrclk)) |-> (slot == SLOT_W'(1))); // R6

endmodule

// File: tb/test_aud_serial_tx.sv
module test_aud_serial_tx;
    localparam int DIV    = 2;
    localparam int NCYC   = 50000;
    localparam int CFG_DW = 1500;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_fmt = 2'd0;
    logic        cfg_alt = 1'b0;
    logic [1:0]  cfg_wl = 2'd0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] in_left = '0, in_right = '0;
    logic        bclk, lrclk, sdo;

    always #2 clk = ~clk;

    aud_serial_tx #(.DIV(DIV)) i_aud_serial_tx (
        .clk(clk), .rst(rst), .cfg_fmt(cfg_fmt), .cfg_alt(cfg_alt), .cfg_wl(cfg_wl),
        .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
        .bclk(bclk), .lrclk(lrclk), .sdo(sdo)
    );

    int vecs = 0, errs = 0;
    bit done = 0;
    int m_dc, m_slot, m_fmt, m_alt, m_wl;
    bit m_bclk, m_lr, m_sdo, m_pv, acc;
    logic [23:0] m_pl, m_pr;
    bit pat_d[64], pat_l[64], pat_u[64];
    logic [31:0] lcg = 32'h1234_5678;

    function automatic int wbits(int wl);
        return (wl == 0) ? 16 : (wl == 1) ? 20 : 24;
    endfunction

    // Lay out one frame: where each sample bit goes and the word-clock level.
    task automatic build_frame(logic [23:0] l, logic [23:0] r);
        int w, base;
        w = wbits(m_wl);
        for (int s = 0; s < 64; s++) begin
            pat_d[s] = 0; pat_u[s] = 1;
            case (m_fmt)
                0: pat_l[s] = (s >= 32) ^ m_alt[0];       // R3, R7
                1, 2: pat_l[s] = (s < 32) ^ m_alt[0];     // R4, R5, R7
                default: pat_l[s] = (s == 0);             // R6
            endcase
        end
        for (int c = 0; c < 2; c++) begin
            for (int k = 0; k < w; k++) begin
                case (m_fmt)
                    0: base = 32 * c + 1;
                    1: base = 32 * c;
                    2: base = 32 * c + 32 - w;
                    default: base = (m_alt ? 0 : 1) + c * w;
                endcase
                pat_d[base + k] = (c == 0) ? l[23 - k] : r[23 - k]; // R8 keep top bits
                pat_u[base + k] = 0;
            end
        end
    endtask

    function automatic string tag_of(bit b_bad, bit l_bad, bit r_bad);
        string fmt_tag;
        fmt_tag = (m_fmt == 0) ? "R3" : (m_fmt == 1) ? "R4" : (m_fmt == 2) ? "R5" : "R6";
        if (rst) return "R1";
        if (b_bad) return "R2";
        if (r_bad) return "R10";
        if (int'(cfg_fmt) != m_fmt || int'(cfg_alt) != m_alt || int'(cfg_wl) != m_wl) return "R11";
        if (l_bad) return (m_alt != 0 && m_fmt != 3) ? "R7" : fmt_tag;
        if (pat_u[m_slot]) return "R9";
        if (m_wl != 2) return "R8";
        return fmt_tag;
    endfunction

    task automatic step_model();
        acc = 0;
        if (rst) begin
            m_dc = DIV - 1; m_slot = 63; m_bclk = 0; m_lr = 0; m_sdo = 0; m_pv = 0;
            m_fmt = 0; m_alt = 0; m_wl = 0;
        end else begin
            acc = in_valid && !m_pv;
            if (m_dc == 2 * DIV - 1) begin
                m_dc = 0;
                m_slot = (m_slot + 1) % 64;
                if (m_slot == 0) begin // R11 latch, R10 consume
                    m_fmt = int'(cfg_fmt); m_alt = int'(cfg_alt); m_wl = int'(cfg_wl);
                    if (m_pv) build_frame(m_pl, m_pr); else build_frame('0, '0);
                    m_pv = 0;
                end
                m_bclk = 0; m_lr = pat_l[m_slot]; m_sdo = pat_d[m_slot];
            end else begin
                if (m_dc == DIV - 1) m_bclk = 1;
                m_dc++;
            end
            if (acc) begin m_pv = 1; m_pl = in_left; m_pr = in_right; end
        end
    endtask

    task automatic compare();
        bit b_bad, l_bad, d_bad, r_bad;
        b_bad = (bclk !== m_bclk);
        l_bad = (lrclk !== m_lr);
        d_bad = (sdo !== m_sdo);
        r_bad = (in_ready !== !m_pv);
        vecs++;
        if (b_bad || l_bad || d_bad || r_bad) begin
            errs++;
            $display("FAIL %s slot %0d: bclk/lrclk/sdo/ready = %0b%0b%0b%0b expected %0b%0b%0b%0b",
                     tag_of(b_bad, l_bad, r_bad), m_slot, bclk, lrclk, sdo, in_ready,
                     m_bclk, m_lr, m_sdo, !m_pv);
        end
    endtask

    task automatic drive(int cyc);
        int combo;
        rst = (cyc < 5); // R1 reset window
        combo = (cyc / CFG_DW) % 32; // every framing, alt and word-length code; R11 mid-frame changes
        cfg_fmt = combo[1:0]; cfg_alt = combo[2]; cfg_wl = combo[4:3];
        if (acc || !in_valid) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            in_valid = (lcg[31:30] != 2'b00) && !((cyc % 5000) > 3000 && (cyc % 5000) < 4300);
            in_left = lcg[23:0] ^ {lcg[7:0], 16'h0};
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            in_right = lcg[27:4];
        end
    endtask

    initial begin
        for (int cyc = 0; cyc < NCYC; cyc++) begin
            @(negedge clk);
            step_model();
            compare();
            drive(cyc);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        #((NCYC + 2000) * 4);
        if (!done) begin
            errs++;
            $display("FAIL watchdog expired: progress %0d expected %0d", vecs, NCYC);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

endmodule